// File: doc/BRIEF.md
# Aligned Transfer Length and Stride Register Slice

This block holds the transfer-length and per-side stride settings of a DMA controller whose read-side and write-side data buses may have different widths. When software writes a length, a fixed group of low-order bits is forced high. The stored value counts bytes minus one, so the effective byte count is always a whole multiple of the wider bus. Both sides of the engine therefore receive one identical length. Without this, each side could round the length up by a different amount and the engine would deadlock.

Each stride is handled according to its own side. When a stride is written, the low-order bits below that side's bus width in bytes are cleared, so every generated address stays aligned. Software can find the alignment rule by reading back. A length write of zero reads back as a mask of ones, and a stride write of all ones reads back with its low bits cleared. A read-only identity word carries a minor revision that advertises this behaviour.

The register port is simple. A write takes effect at the next clock edge. A read returns its data one cycle after the request, together with a valid flag. The cleaned-up values are also driven continuously to the transfer logic.

Top module: `dma_align_regs`

## Requirements
- R1: After reset, the length reads back as 2^K-1 and both strides read back as 0. K is log2 of the larger bus width in bytes.
- R2: A length write (word address 1) stores the written value truncated to LEN_BITS, with bits [K-1:0] forced to 1. The upper bits are kept as written.
- R3: A length write of zero reads back as 2^K-1, which reveals the alignment requirement.
- R4: A source stride write (word address 2) stores the value truncated to STRIDE_BITS, with bits [S-1:0] cleared. S is log2 of the source bus width in bytes.
- R5: A destination stride write (word address 3) stores the value truncated to STRIDE_BITS, with bits [D-1:0] cleared. D is log2 of the destination bus width in bytes.
- R6: The exported source-side and destination-side lengths are always equal, and both equal the length read-back. The exported strides equal their read-back values. When both buses have the same width, all masks come from that one width.
- R7: Word address 0 reads as the constant {VER_MAJOR[15:0], VER_MINOR[7:0], VER_PATCH[7:0]}. Writes to that address change nothing.
- R8: A read request yields rdValid high with the data in the next cycle, and rdValid is low in other cycles. Addresses 4 and above read as zero, and writes to them change nothing.
- R9: A register changes only at the clock edge that samples a write to its own address. Its exported value shows the new contents in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| wrAddr | input | ADDR_BITS | Write word address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_BITS | Read word address |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | 32 | Read data |
| srcXferLen | output | LEN_BITS | Length, bytes minus one, for the read side |
| dstXferLen | output | LEN_BITS | Length, bytes minus one, for the write side |
| srcStride | output | STRIDE_BITS | Aligned source stride |
| dstStride | output | STRIDE_BITS | Aligned destination stride |

## Verification
The hardest case to reach is a configuration where the two buses differ in width, because only then can the length mask differ from one of the stride masks. To get there, the bench drives the same writes into two instances: one with 64-bit and 128-bit buses, and one with equal 32-bit buses. It sweeps every low-order pattern of each register, plus several upper-bit patterns. Read-back and the exported ports are then compared against masks the bench computes from the two widths.

// File: rtl/dma_align_pkg.sv
package dma_align_pkg;
  localparam int unsigned DATA_BITS = 32;
  localparam int unsigned ADR_IDENT = 0;
  localparam int unsigned ADR_LEN = 1;
  localparam int unsigned ADR_SRC_STRIDE = 2;
  localparam int unsigned ADR_DST_STRIDE = 3;

  typedef enum logic [2:0] {
    SEL_IDENT,
    SEL_LEN,
    SEL_SRC_STRIDE,
    SEL_DST_STRIDE,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic       wrLen;
    logic [1:0] wrStride;
    logic       rdFire;
    rdSel_e     rdSel;
  } regStrobe_t;

  function automatic int unsigned bytesLog(input int unsigned busBits);
    return $clog2(busBits / 8);
  endfunction
endpackage

// File: rtl/dma_align_ctrl.sv
module dma_align_ctrl
  import dma_align_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] wrAddr,
  input  logic                 rdEn,
  input  logic [ADDR_BITS-1:0] rdAddr,
  output regStrobe_t           strobe,
  output logic                 rdValid
);
  logic rdValidQ;

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = SEL_NONE;
    strobe.rdFire   = rdEn;
    if (wrEn) begin
      unique case (32'(wrAddr))
        ADR_LEN:        strobe.wrLen = 1'b1;
        ADR_SRC_STRIDE: strobe.wrStride[0] = 1'b1;
        ADR_DST_STRIDE: strobe.wrStride[1] = 1'b1;
        default:        ;
      endcase
    end
    unique case (32'(rdAddr))
      ADR_IDENT:      strobe.rdSel = SEL_IDENT;
      ADR_LEN:        strobe.rdSel = SEL_LEN;
      ADR_SRC_STRIDE: strobe.rdSel = SEL_SRC_STRIDE;
      ADR_DST_STRIDE: strobe.rdSel = SEL_DST_STRIDE;
      default:        strobe.rdSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= rdEn;
  end

  assign rdValid = rdValidQ;

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrLen, strobe.wrStride})); // R8
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R8
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R8
endmodule

// File: rtl/dma_align_datapath.sv
module dma_align_datapath
  import dma_align_pkg::*;
#(
  parameter int unsigned SRC_BUS_BITS = 64,
  parameter int unsigned DST_BUS_BITS = 128,
  parameter int unsigned LEN_BITS     = 16,
  parameter int unsigned STRIDE_BITS  = 16,
  parameter logic [DATA_BITS-1:0] IDENT_WORD = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic [DATA_BITS-1:0]   wrData,
  output logic [DATA_BITS-1:0]   rdData,
  output logic [LEN_BITS-1:0]    srcXferLen,
  output logic [LEN_BITS-1:0]    dstXferLen,
  output logic [STRIDE_BITS-1:0] srcStride,
  output logic [STRIDE_BITS-1:0] dstStride
);
  localparam int unsigned SRC_LOG = bytesLog(SRC_BUS_BITS);
  localparam int unsigned DST_LOG = bytesLog(DST_BUS_BITS);
  localparam int unsigned LEN_LOG = (SRC_LOG > DST_LOG) ? SRC_LOG : DST_LOG;
  localparam logic [LEN_BITS-1:0] LEN_SET_MASK =
    LEN_BITS'((64'd1 << LEN_LOG) - 64'd1);
  localparam int unsigned SIDE_LOG [2] = '{SRC_LOG, DST_LOG};

  logic [LEN_BITS-1:0]    lenQ;
  logic [STRIDE_BITS-1:0] strideQ [2];
  logic [DATA_BITS-1:0]   rdDataQ;

  always_ff @(posedge clk) begin
    if (!rstN)             lenQ <= LEN_SET_MASK;
    else if (strobe.wrLen) lenQ <= wrData[LEN_BITS-1:0] | LEN_SET_MASK;
  end

  for (genvar side = 0; side < 2; side++) begin : g_stride
    localparam logic [STRIDE_BITS-1:0] CLR_MASK =
      STRIDE_BITS'((64'd1 << SIDE_LOG[side]) - 64'd1);
    always_ff @(posedge clk) begin
      if (!rstN)                      strideQ[side] <= '0;
      else if (strobe.wrStride[side]) strideQ[side] <= wrData[STRIDE_BITS-1:0] & ~CLR_MASK;
    end

    AST_STRIDE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrStride[side] |=> $stable(strideQ[side])); // R9
    AST_STRIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
      (strideQ[side] & CLR_MASK) == '0); // R4 R5
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdDataQ <= '0;
    else if (strobe.rdFire) begin
      unique case (strobe.rdSel)
        SEL_IDENT:      rdDataQ <= IDENT_WORD;
        SEL_LEN:        rdDataQ <= DATA_BITS'(lenQ);
        SEL_SRC_STRIDE: rdDataQ <= DATA_BITS'(strideQ[0]);
        SEL_DST_STRIDE: rdDataQ <= DATA_BITS'(strideQ[1]);
        default:        rdDataQ <= '0;
      endcase
    end
  end

  assign rdData     = rdDataQ;
  assign srcXferLen = lenQ;
  assign dstXferLen = lenQ;
  assign srcStride  = strideQ[0];
  assign dstStride  = strideQ[1];

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrLen |=> $stable(lenQ)); // R9
  AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (srcXferLen & LEN_SET_MASK) == LEN_SET_MASK); // R2
endmodule

// File: rtl/dma_align_regs.sv
module dma_align_regs
  import dma_align_pkg::*;
#(
  parameter int unsigned ADDR_BITS    = 4,
  parameter int unsigned SRC_BUS_BITS = 64,
  parameter int unsigned DST_BUS_BITS = 128,
  parameter int unsigned LEN_BITS     = 16,
  parameter int unsigned STRIDE_BITS  = 16,
  parameter logic [15:0] VER_MAJOR    = 16'd4,
  parameter logic [7:0]  VER_MINOR    = 8'd3,
  parameter logic [7:0]  VER_PATCH    = 8'd0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_BITS-1:0]   wrAddr,
  input  logic [31:0]            wrData,
  input  logic                   rdEn,
  input  logic [ADDR_BITS-1:0]   rdAddr,
  output logic                   rdValid,
  output logic [31:0]            rdData,
  output logic [LEN_BITS-1:0]    srcXferLen,
  output logic [LEN_BITS-1:0]    dstXferLen,
  output logic [STRIDE_BITS-1:0] srcStride,
  output logic [STRIDE_BITS-1:0] dstStride
);
  localparam logic [31:0] IDENT_WORD = {VER_MAJOR, VER_MINOR, VER_PATCH};

  regStrobe_t strobe;

  dma_align_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe), .rdValid(rdValid)
  );

  dma_align_datapath #(
    .SRC_BUS_BITS(SRC_BUS_BITS), .DST_BUS_BITS(DST_BUS_BITS),
    .LEN_BITS(LEN_BITS), .STRIDE_BITS(STRIDE_BITS), .IDENT_WORD(IDENT_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData),
    .srcXferLen(srcXferLen), .dstXferLen(dstXferLen),
    .srcStride(srcStride), .dstStride(dstStride)
  );

  AST_SAME_LEN: assert property (@(posedge clk) disable iff (!rstN)
    srcXferLen == dstXferLen); // R6
  AST_IDENT_CONST: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && ($past(rdAddr) == ADDR_BITS'(ADR_IDENT)) |-> rdData == IDENT_WORD); // R7
endmodule

// File: tb/dma_align_regs_tb.sv
module dma_align_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic rdValidA, rdValidB;
  logic [31:0] rdDataA, rdDataB;
  logic [15:0] sLenA, dLenA, sStrA, dStrA, sLenB, dLenB, sStrB, dStrB;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_align_regs u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValidA), .rdData(rdDataA),
    .srcXferLen(sLenA), .dstXferLen(dLenA), .srcStride(sStrA), .dstStride(dStrA));

  dma_align_regs #(.SRC_BUS_BITS(32), .DST_BUS_BITS(32)) u_dutEq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValidB), .rdData(rdDataB),
    .srcXferLen(sLenB), .dstXferLen(dLenB), .srcStride(sStrB), .dstStride(dStrB));

  // Masks from the widths: A has 64/128-bit buses (S=3, D=4, K=4); B has 32/32 (all 2).
  localparam logic [31:0] IDENT = 32'h0004_0300;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int adr, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = 4'(adr); wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input int adr, output logic [31:0] a, output logic [31:0] b, input string req);
    @(negedge clk); rdEn = 1'b1; rdAddr = 4'(adr);
    @(negedge clk); rdEn = 1'b0;
    chk(rdValidA && rdValidB, req, {rdValidA, rdValidB}, 2'b11);
    a = rdDataA; b = rdDataB;
    @(negedge clk);
    chk(!rdValidA && !rdValidB, "R8", {rdValidA, rdValidB}, 0);
  endtask

  task automatic expectAll(input logic [15:0] eLA, eSA, eDA, eLB, eSB, eDB, input string req);
    logic [31:0] a, b;
    rd(1, a, b, req);
    chk(a == 32'(eLA) && b == 32'(eLB), req, {a, b}, {32'(eLA), 32'(eLB)});
    rd(2, a, b, req);
    chk(a == 32'(eSA) && b == 32'(eSB), req, {a, b}, {32'(eSA), 32'(eSB)});
    rd(3, a, b, req);
    chk(a == 32'(eDA) && b == 32'(eDB), req, {a, b}, {32'(eDA), 32'(eDB)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [15:0] eLA, eLB, eSA, eDA, eSB, eDB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectAll(16'h000F, 16'h0000, 16'h0000, 16'h0003, 16'h0000, 16'h0000, "R1");
    // R3 zero length probe
    wr(1, 32'h0);
    rd(1, a, b, "R3");
    chk(a == 32'hF && b == 32'h3, "R3", {a, b}, {32'hF, 32'h3});
    // R2 R4 R5 R6 R9 sweep
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = 32'(i) ^ (32'(i % 7) << 9) ^ ((i % 3 == 0) ? 32'hABCD_0000 : 32'h0);
      eLA = w[15:0] | 16'h000F; eLB = w[15:0] | 16'h0003;
      wr(1, w);
      chk(sLenA == eLA && dLenA == eLA, "R2/R6 len port A", {sLenA, dLenA}, {eLA, eLA});
      chk(sLenB == eLB && dLenB == eLB, "R6 len port equal-width", {sLenB, dLenB}, {eLB, eLB});
      rd(1, a, b, "R2");
      chk(a == 32'(eLA) && b == 32'(eLB), "R2", {a, b}, {32'(eLA), 32'(eLB)});
      eSA = w[15:0] & 16'hFFF8; eSB = w[15:0] & 16'hFFFC;
      wr(2, w);
      chk(sStrA == eSA && sStrB == eSB, "R4 port", {sStrA, sStrB}, {eSA, eSB});
      rd(2, a, b, "R4");
      chk(a == 32'(eSA) && b == 32'(eSB), "R4", {a, b}, {32'(eSA), 32'(eSB)});
      eDA = ~w[15:0] & 16'hFFF0; eDB = ~w[15:0] & 16'hFFFC;
      wr(3, ~w);
      chk(dStrA == eDA && dStrB == eDB, "R5 port", {dStrA, dStrB}, {eDA, eDB});
      chk(sStrA == eSA && sLenA == eLA, "R9 others held", {sStrA, sLenA}, {eSA, eLA});
      rd(3, a, b, "R5");
      chk(a == 32'(eDA) && b == 32'(eDB), "R5", {a, b}, {32'(eDA), 32'(eDB)});
    end
    // Known state, then R7 and R8 ignored writes
    wr(1, 32'h1230); wr(2, 32'h0457); wr(3, 32'h0899);
    wr(0, 32'hFFFF_FFFF);
    rd(0, a, b, "R7");
    chk(a == IDENT && b == IDENT, "R7", {a, b}, {IDENT, IDENT});
    for (int adr = 4; adr < 16; adr++) begin
      wr(adr, 32'h5555_AAAA);
      rd(adr, a, b, "R8");
      chk(a == 0 && b == 0, "R8 unmapped read", {a, b}, 0);
    end
    expectAll(16'h123F, 16'h0450, 16'h0890, 16'h1233, 16'h0454, 16'h0898, "R7/R8 unchanged");
    // R9 write timing: value visible after sampling edge only
    @(negedge clk); wrEn = 1'b1; wrAddr = 4'd2; wrData = 32'h0000_7FFF;
    chk(sStrA == 16'h0450, "R9 before edge", sStrA, 16'h0450);
    @(negedge clk); wrEn = 1'b0;
    chk(sStrA == 16'h7FF8 && sStrB == 16'h7FFC, "R9 after edge", {sStrA, sStrB}, {16'h7FF8, 16'h7FFC});
    // R1 reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    expectAll(16'h000F, 16'h0000, 16'h0000, 16'h0003, 16'h0000, 16'h0000, "R1 re-reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule